// File: doc/BRIEF.md
# SDRAM Read Data Capture and System-Clock Resynchronizer

This block takes read data coming back from a single-data-rate SDRAM and delivers it, word by word, as write traffic for a read FIFO that runs on the system clock. The data bus is sampled on the rising edge of a dedicated capture clock. That clock has the same frequency as the system clock, and its phase is trimmed outside the block to centre the sampling point in the data eye. The captured word is then taken into the system clock domain by a register on either the rising or the falling edge of the system clock. A static select input chooses the edge, so the crossing can use whichever edge has the wider margin for the chosen capture phase.

Each read command strobe marks one returned word. A read-valid flag enters a shift line. A programmable tap chooses how many system cycles pass before that flag turns into a FIFO write. The tap value must account for the CAS latency, any register stage on the board, and the flight time measured against the clock period. Every valid flag produces exactly one write, and the written word is the one that sits in the resync stage at that moment.

Top module: `sdram_rdcap`

## Requirements
- R1: The data bus is registered on the rising edge of `cap_clk` only. A word held stable across a capture-clock rising edge is the value that moves on toward the FIFO.
- R2: With `cfg_fall_edge` = 0, the captured word is re-registered on the rising edge of `sys_clk`. A word that is in the capture register at rising edge e reaches `fifo_wdata` after rising edge e+1.
- R3: With `cfg_fall_edge` = 1, the captured word is re-registered on the falling edge of `sys_clk`. A word that is in the capture register at the falling edge just before rising edge e reaches `fifo_wdata` after rising edge e. This is one cycle earlier than with R2.
- R4: If `rd_cmd` is sampled high at rising edge k, `fifo_we` is high for the single cycle that follows rising edge k+D, where D is `cfg_delay` (0 to 7).
- R5: No write happens without a command. When no strobe is outstanding, `fifo_we` stays low whatever the data bus does.
- R6: A burst of N strobes on consecutive cycles gives exactly N writes on consecutive cycles, carrying the words in the order they were returned.
- R7: While `rst_n` is low, `fifo_we` is 0 and `fifo_wdata` is all zeros. The reset is asserted asynchronously and released through a two-flop synchronizer in each clock domain. `fifo_wdata` changes only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; resync, delay line and FIFO write side |
| cap_clk | input | 1 | Capture clock, same frequency as sys_clk, externally phased |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | Read strobe, one per expected data word, sys_clk domain |
| cfg_delay | input | DELAY_W (3) | Cycles from strobe to FIFO write, 0 to 7 |
| cfg_fall_edge | input | 1 | 0: resync on sys_clk rising edge, 1: on falling edge |
| dq_in | input | DATA_W (16) | SDRAM read data bus |
| fifo_wdata | output | DATA_W (16) | Read FIFO write data |
| fifo_we | output | 1 | Read FIFO write enable |

## Verification
The assertions assume three things about the inputs. Both configuration inputs stay constant while any strobe is still in the delay line. `rd_cmd` changes only between system rising edges. The capture-clock phase leaves setup margin for the selected resync edge. The stimulus changes configuration only after the pipeline has drained for a dozen idle cycles, drives strobes one nanosecond after the edge, and runs the capture clock a quarter period behind the system clock. The memory model launches each word on the capture falling edge, so both resync edges see stable data. Under those conditions the model's return latency fixes the matching delay, and the bench sweeps every latency that fits the delay range on both edges.

// File: rtl/sdram_rdcap_pkg.sv
package sdram_rdcap_pkg;
  typedef enum logic {
    RESYNC_RISE = 1'b0,
    RESYNC_FALL = 1'b1
  } resync_edge_e;

  function automatic int unsigned tap_count(input int unsigned sel_w);
    return 32'd1 << sel_w;
  endfunction
endpackage

// File: rtl/sdram_rdcap_rst_sync.sv
module sdram_rdcap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/sdram_rdcap_capture.sv
module sdram_rdcap_capture #(
  parameter int DATA_W = 16
) (
  input  logic              cap_clk,
  input  logic              cap_rst_n,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] cap_data
);
  logic [DATA_W-1:0] cap_q;
  logic [DATA_W-1:0] cap_d;

  always_comb cap_d = dq_in;

  always_ff @(posedge cap_clk or negedge cap_rst_n) begin
    if (!cap_rst_n) cap_q <= '0;
    else            cap_q <= cap_d;
  end

  assign cap_data = cap_q;
endmodule

// File: rtl/sdram_rdcap_resync.sv
module sdram_rdcap_resync
  import sdram_rdcap_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  resync_edge_e      edge_sel,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] rs_data
);
  logic [DATA_W-1:0] rise_q, rise_d;
  logic [DATA_W-1:0] fall_q, fall_d;

  always_comb begin
    rise_d = cap_data;
    fall_d = cap_data;
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) rise_q <= '0;
    else            rise_q <= rise_d;
  end

  always_ff @(negedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) fall_q <= '0;
    else            fall_q <= fall_d;
  end

  always_comb rs_data = (edge_sel == RESYNC_FALL) ? fall_q : rise_q;
endmodule

// File: rtl/sdram_rdcap_rden_dly.sv
module sdram_rdcap_rden_dly
  import sdram_rdcap_pkg::*;
#(
  parameter int DELAY_W = 3
) (
  input  logic               sys_clk,
  input  logic               sys_rst_n,
  input  logic               rd_cmd,
  input  logic [DELAY_W-1:0] cfg_delay,
  output logic               rd_valid
);
  localparam int DEPTH = int'(tap_count(DELAY_W));

  logic [DEPTH-2:0] vld_q;
  logic [DEPTH-2:0] vld_d;
  logic [DEPTH-1:0] taps;

  assign taps = {vld_q, rd_cmd};

  always_comb vld_d = taps[DEPTH-2:0];

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) vld_q <= '0;
    else            vld_q <= vld_d;
  end

  assign rd_valid = taps[cfg_delay];
endmodule

// File: rtl/sdram_rdcap.sv
module sdram_rdcap
  import sdram_rdcap_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DELAY_W = 3
) (
  input  logic               sys_clk,
  input  logic               cap_clk,
  input  logic               rst_n,
  input  logic               rd_cmd,
  input  logic [DELAY_W-1:0] cfg_delay,
  input  logic               cfg_fall_edge,
  input  logic [DATA_W-1:0]  dq_in,
  output logic [DATA_W-1:0]  fifo_wdata,
  output logic               fifo_we
);
  localparam int DEPTH = int'(tap_count(DELAY_W));

  logic              sys_rst_n;
  logic              cap_rst_n;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] rs_data;
  logic              rd_valid;
  resync_edge_e      edge_sel;

  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              we_q, we_d;

  assign edge_sel = resync_edge_e'(cfg_fall_edge);

  sdram_rdcap_rst_sync u_sys_rst (
    .clk        (sys_clk),
    .rst_n      (rst_n),
    .rst_sync_n (sys_rst_n)
  );

  sdram_rdcap_rst_sync u_cap_rst (
    .clk        (cap_clk),
    .rst_n      (rst_n),
    .rst_sync_n (cap_rst_n)
  );

  sdram_rdcap_capture #(.DATA_W(DATA_W)) u_capture (
    .cap_clk   (cap_clk),
    .cap_rst_n (cap_rst_n),
    .dq_in     (dq_in),
    .cap_data  (cap_data)
  );

  sdram_rdcap_resync #(.DATA_W(DATA_W)) u_resync (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .edge_sel  (edge_sel),
    .cap_data  (cap_data),
    .rs_data   (rs_data)
  );

  sdram_rdcap_rden_dly #(.DELAY_W(DELAY_W)) u_rden (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .rd_cmd    (rd_cmd),
    .cfg_delay (cfg_delay),
    .rd_valid  (rd_valid)
  );

  // FIFO write stage: data register enabled only by a valid flag
  always_comb begin
    we_d    = rd_valid;
    wdata_d = rd_valid ? rs_data : wdata_q;
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      we_q    <= we_d;
      wdata_q <= wdata_d;
    end
  end

  assign fifo_we    = we_q;
  assign fifo_wdata = wdata_q;

  // Strobes accepted but not yet written, used by the checks below
  logic [DELAY_W:0] inflight_q, inflight_d;

  always_comb inflight_d = inflight_q + {{DELAY_W{1'b0}}, rd_cmd} - {{DELAY_W{1'b0}}, we_q};

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) inflight_q <= '0;
    else            inflight_q <= inflight_d;
  end

  assert_dly0_R4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (rd_cmd && cfg_delay == '0) |=> fifo_we);

  assert_dly1_R4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (rd_cmd && cfg_delay == DELAY_W'(1)) |=> ##1 fifo_we);

  assert_cfg_hold_R4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (inflight_q != '0) |-> ($stable(cfg_delay) && $stable(cfg_fall_edge)));

  assert_no_spurious_R5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    fifo_we |-> (inflight_q != '0));

  assert_inflight_bound_R6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    inflight_q <= (DELAY_W+1)'(DEPTH));

  assert_wdata_hold_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !fifo_we |-> $stable(fifo_wdata));
endmodule

// File: tb/sdram_rdcap_tb.sv
`timescale 1ns/1ps
module sdram_rdcap_tb;
  localparam int DW = 16;
  localparam int LW = 3;

  logic          sys_clk = 1'b0;
  logic          cap_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_cmd = 1'b0;
  logic [LW-1:0] cfg_delay = '0;
  logic          cfg_fall_edge = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] fifo_wdata;
  logic          fifo_we;

  sdram_rdcap #(.DATA_W(DW), .DELAY_W(LW)) u_dut (
    .sys_clk(sys_clk), .cap_clk(cap_clk), .rst_n(rst_n), .rd_cmd(rd_cmd),
    .cfg_delay(cfg_delay), .cfg_fall_edge(cfg_fall_edge), .dq_in(dq_in),
    .fifo_wdata(fifo_wdata), .fifo_we(fifo_we)
  );

  always #2.5 sys_clk = ~sys_clk;
  initial begin
    #3.75;
    forever begin cap_clk = 1'b1; #2.5; cap_clk = 1'b0; #2.5; end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int s);
    return DW'(s * 32'h2B9D + 32'h0137);
  endfunction

  // memory model and command history
  int            lat = 0;
  int            ecnt = 100;
  int            wseq = 0;
  int            exp_wr = 0;
  int            exp_rd = 0;
  int            slot_t [32];
  logic [DW-1:0] slot_d [32];
  logic [DW-1:0] exp_q  [256];
  bit            cmd_hist [64];

  always @(posedge sys_clk) begin
    if (rd_cmd) begin
      slot_t[(ecnt + lat) % 32] <= ecnt + lat;
      slot_d[(ecnt + lat) % 32] <= word_of(wseq);
      exp_q[exp_wr % 256]       <= word_of(wseq);
      exp_wr <= exp_wr + 1;
      wseq   <= wseq + 1;
    end
    cmd_hist[ecnt % 64] <= rd_cmd;
    ecnt <= ecnt + 1;
  end

  // word launched on capture falling edge, idle cycles carry noise (R5)
  always @(negedge cap_clk) begin
    int n;
    n = ecnt - 1;
    if (slot_t[n % 32] == n) dq_in <= slot_d[n % 32];
    else                     dq_in <= DW'(32'hA5A5 ^ (n * 7));
  end

  // monitor
  bit    mon_en = 1'b0;
  bit    data_chk = 1'b0;
  string data_tag = "R1 R2";
  int    writes = 0;

  always begin
    @(posedge sys_clk);
    #2;
    if (mon_en) begin
      bit ew;
      ew = cmd_hist[(ecnt - 1 - int'(cfg_delay)) % 64];
      check(fifo_we == ew, "R4 R5 write timing", int'(fifo_we), int'(ew));
      if (fifo_we) begin
        if (data_chk)
          check(fifo_wdata == exp_q[exp_rd % 256], {data_tag, " R6 data"},
                int'(fifo_wdata), int'(exp_q[exp_rd % 256]));
        exp_rd = exp_rd + 1;
        writes = writes + 1;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge sys_clk); #1; rd_cmd = 1'b0; end
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin @(posedge sys_clk); #1; rd_cmd = 1'b1; end
    @(posedge sys_clk); #1; rd_cmd = 1'b0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    // R7: reset state
    idle(4);
    @(posedge sys_clk); #2;
    check(fifo_we == 1'b0, "R7 reset we", int'(fifo_we), 0);
    check(fifo_wdata == '0, "R7 reset wdata", int'(fifo_wdata), 0);
    #1; rst_n = 1'b1;
    idle(6);
    mon_en = 1'b1;

    // R5: noise on the bus with nothing outstanding
    begin
      int w0;
      w0 = writes;
      idle(40);
      check(writes == w0, "R5 idle writes", writes - w0, 0);
    end

    // R4: every delay tap, timing only
    data_chk = 1'b0;
    for (int d = 0; d < 8; d++) begin
      cfg_delay = LW'(d);
      idle(2);
      burst(1);
      idle(12);
      burst(3);
      idle(12);
      check(exp_rd == exp_wr, "R4 R6 write count", exp_rd, exp_wr);
    end

    // R1 R2 R3 R6: data sweep over latency and resync edge
    data_chk = 1'b1;
    for (int fe = 0; fe < 2; fe++) begin
      for (int l = 0; l < 5; l++) begin
        cfg_fall_edge = fe[0];
        lat = l;
        cfg_delay = LW'(l + 3 - fe);
        data_tag = (fe == 0) ? "R1 R2" : "R1 R3";
        idle(4);
        burst(1);
        idle(3);
        burst(4);
        idle(2);
        burst(7);
        burst(2);
        idle(14);
        check(exp_rd == exp_wr, "R6 burst count", exp_rd, exp_wr);
      end
    end

    // R7: write data holds after the last write
    begin
      logic [DW-1:0] last;
      last = fifo_wdata;
      idle(10);
      check(fifo_wdata == last, "R7 data hold", int'(fifo_wdata), int'(last));
    end

    finished = 1'b1;
    finish_run();
  end
endmodule